// File: doc/BRIEF.md
# Request/Acknowledge Handshake Monitor

This block watches a single-bit request/acknowledge pair and reports when the pair breaks the handshake rules. It is synthesizable, so it can stay in silicon as a live protocol guard next to the interface it observes. Each request is expected to get exactly one acknowledge. That acknowledge must arrive no sooner than `MIN_ACK` and no later than `MAX_ACK` clock cycles after the request edge.

A new request is the cycle in which `req` is sampled high after being low. A new acknowledge is the matching edge on `ack`. A three-state machine (idle, waiting for acknowledge, acknowledged) together with a small latency counter sorts each violation into one of four classes. Each class has its own flag, and each flag stays set until reset. A one-cycle error pulse marks every cycle in which at least one violation was detected. Only one transaction is tracked at a time, and data is not checked.

The external reset is asynchronous and active-low. Internally it is released through a two-stage synchronizer, so the monitor starts observing two clock edges after `rst_n` rises.

Top module: `hs_monitor`

## Requirements
- R1: A request counts only on a rising edge of `req` (high now, low the cycle before). A `req` held high after a finished or timed-out transaction starts nothing new and raises no error.
- R2: A request edge seen while a request is still waiting for its acknowledge sets `err_overlap`. The wait for the original acknowledge continues with its timing unchanged.
- R3: An acknowledge edge while no request is waiting and no request edge occurs in the same cycle sets `err_spurious`. This includes the case after a timeout.
- R4: A further acknowledge edge after the request has been acknowledged, and before `req` falls, sets `err_dup_ack`.
- R5: An acknowledge edge fewer than `MIN_ACK` cycles after the request edge sets `err_latency` and returns the monitor to idle. With `MIN_ACK=1`, this covers request and acknowledge edges in the same cycle.
- R6: If no acknowledge edge has arrived by `MAX_ACK` cycles after the request edge, `err_latency` is set in that cycle and the monitor returns to idle. One cycle earlier, no flag is set.
- R7: An acknowledge edge exactly `MIN_ACK` or exactly `MAX_ACK` cycles after the request, or anywhere between, sets no flag. Defaults are `MIN_ACK=1`, `MAX_ACK=3`.
- R8: Reset clears all four flags and the pulse and puts the monitor in idle. Once set, a flag stays set through any later traffic until the next reset.
- R9: Flags and `err_pulse` are registered. They show a violation one clock after the edge that sampled it. `err_pulse` is high for exactly that cycle unless a new violation follows.
- R10: A request edge and a valid acknowledge edge in the same cycle during a wait are both evaluated. `err_overlap` is set and the pending request is accepted as acknowledged, with no latency error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Observed request |
| ack | input | 1 | Observed acknowledge |
| err_overlap | output | 1 | Sticky: new request while one is waiting |
| err_spurious | output | 1 | Sticky: acknowledge with no waiting request |
| err_dup_ack | output | 1 | Sticky: second acknowledge for one request |
| err_latency | output | 1 | Sticky: acknowledge too early or missing by the deadline |
| err_pulse | output | 1 | One-cycle pulse for each cycle that detects a violation |

## Verification
The interesting coincidence is a second request edge landing in the same cycle as a legal acknowledge of the first. The monitor must raise the overlap flag and also accept the acknowledge, rather than letting one decision mask the other. The bench provokes this by dropping `req` one cycle after the request and raising `req` and `ack` together on the following cycle. It then expects only `err_overlap` and a single pulse, with no latency or spurious flag, and no duplicate flag while `ack` is held afterwards.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_ACKED = 2'd2
  } hs_state_e;

  localparam int F_OVL  = 0;
  localparam int F_SPUR = 1;
  localparam int F_DUP  = 2;
  localparam int F_LAT  = 3;
  localparam int NUM_F  = 4;

endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hs_rise_detect.sv
module hs_rise_detect #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/hs_latency_timer.sv
module hs_latency_timer #(
  parameter int MIN_ACK = 1,
  parameter int MAX_ACK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic early_o,
  output logic at_max_o
);
  localparam int CNT_W = (MAX_ACK < 1) ? 1 : $clog2(MAX_ACK + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = start_i | run_i;
  assign cnt_d  = start_i ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (MIN_ACK == 0) begin : g_no_min
      assign early_o = 1'b0;
    end else begin : g_min
      assign early_o = (cnt_q < CNT_W'(MIN_ACK));
    end
  endgenerate

  assign at_max_o = (cnt_q == CNT_W'(MAX_ACK));
endmodule

// File: rtl/hs_fault_flags.sv
module hs_fault_flags #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] event_i,
  output logic [NUM-1:0] flag_o,
  output logic           pulse_o
);
  generate
    for (genvar i = 0; i < NUM; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_o[i] <= 1'b0;
        else if (event_i[i]) flag_o[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= |event_i;
  end
endmodule

// File: rtl/hs_monitor.sv
module hs_monitor
  import hs_mon_pkg::*;
#(
  parameter int MIN_ACK = 1,
  parameter int MAX_ACK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic err_overlap,
  output logic err_spurious,
  output logic err_dup_ack,
  output logic err_latency,
  output logic err_pulse
);
  localparam bit ZERO_OK = (MIN_ACK == 0);

  logic             rst_sync_n;
  logic [1:0]       rises;
  logic             req_rise;
  logic             ack_rise;
  logic             tmr_start;
  logic             tmr_run;
  logic             tmr_early;
  logic             tmr_at_max;
  logic [NUM_F-1:0] fault_ev;
  logic [NUM_F-1:0] flags;
  hs_state_e        state_q;
  hs_state_e        state_d;

  hs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hs_rise_detect #(.WIDTH(2)) u_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_i  ({ack, req}),
    .rise_o (rises)
  );
  assign req_rise = rises[0];
  assign ack_rise = rises[1];

  hs_latency_timer #(.MIN_ACK(MIN_ACK), .MAX_ACK(MAX_ACK)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (tmr_start),
    .run_i    (tmr_run),
    .early_o  (tmr_early),
    .at_max_o (tmr_at_max)
  );

  // next-state and fault classification
  always_comb begin
    state_d   = state_q;
    fault_ev  = '0;
    tmr_start = 1'b0;
    tmr_run   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_rise) begin
          if (ack_rise && !ZERO_OK) begin
            fault_ev[F_LAT] = 1'b1;
          end else if (ack_rise) begin
            state_d = ST_ACKED;
          end else begin
            state_d   = ST_PEND;
            tmr_start = 1'b1;
          end
        end else if (ack_rise) begin
          fault_ev[F_SPUR] = 1'b1;
        end
      end
      ST_PEND: begin
        if (req_rise) fault_ev[F_OVL] = 1'b1;
        if (ack_rise) begin
          if (tmr_early) begin
            fault_ev[F_LAT] = 1'b1;
            state_d         = ST_IDLE;
          end else begin
            state_d = ST_ACKED;
          end
        end else if (tmr_at_max) begin
          fault_ev[F_LAT] = 1'b1;
          state_d         = ST_IDLE;
        end else begin
          tmr_run = 1'b1;
        end
      end
      ST_ACKED: begin
        if (ack_rise) fault_ev[F_DUP] = 1'b1;
        if (!req)     state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  hs_fault_flags #(.NUM(NUM_F)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .event_i (fault_ev),
    .flag_o  (flags),
    .pulse_o (err_pulse)
  );

  assign err_overlap  = flags[F_OVL];
  assign err_spurious = flags[F_SPUR];
  assign err_dup_ack  = flags[F_DUP];
  assign err_latency  = flags[F_LAT];
endmodule

// File: rtl/hs_monitor_chk.sv
module hs_monitor_chk
  import hs_mon_pkg::*;
#(
  parameter int MIN_ACK = 1,
  parameter int MAX_ACK = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       ack,
  input logic [1:0] state_q,
  input logic       err_overlap,
  input logic       err_spurious,
  input logic       err_dup_ack,
  input logic       err_latency,
  input logic       err_pulse
);
  logic        req_p, ack_p;
  logic        req_r, ack_r;
  int unsigned pend_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_p    <= 1'b0;
      ack_p    <= 1'b0;
      pend_cyc <= 0;
    end else begin
      req_p    <= req;
      ack_p    <= ack;
      pend_cyc <= (state_q == ST_PEND) ? pend_cyc + 1 : 0;
    end
  end

  assign req_r = req & ~req_p;
  assign ack_r = ack & ~ack_p;

  a_r1_held_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req && req_p && !ack_r) |=> (state_q == ST_IDLE));

  a_r2_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && req_r) |=> err_overlap);

  a_r3_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !req_r && ack_r) |=> err_spurious);

  a_r4_dup_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACKED && ack_r) |=> err_dup_ack);

  a_r5_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (MIN_ACK > 0 && state_q == ST_IDLE && req_r && ack_r) |=> err_latency);

  a_r6_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && !ack_r && pend_cyc == unsigned'(MAX_ACK - 1))
      |=> (err_latency && state_q == ST_IDLE));

  a_r8_sticky_ovl: assert property (@(posedge clk) disable iff (!rst_n)
    err_overlap |=> err_overlap);
  a_r8_sticky_spur: assert property (@(posedge clk) disable iff (!rst_n)
    err_spurious |=> err_spurious);
  a_r8_sticky_dup: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup_ack |=> err_dup_ack);
  a_r8_sticky_lat: assert property (@(posedge clk) disable iff (!rst_n)
    err_latency |=> err_latency);

  a_r9_pulse_on_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_overlap) || $rose(err_spurious) || $rose(err_dup_ack) || $rose(err_latency))
      |-> err_pulse);
endmodule

bind hs_monitor hs_monitor_chk #(.MIN_ACK(MIN_ACK), .MAX_ACK(MAX_ACK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req          (req),
  .ack          (ack),
  .state_q      (state_q),
  .err_overlap  (err_overlap),
  .err_spurious (err_spurious),
  .err_dup_ack  (err_dup_ack),
  .err_latency  (err_latency),
  .err_pulse    (err_pulse)
);

// File: tb/hs_monitor_bench.sv
`timescale 1ns/1ps
module hs_monitor_bench;
  logic clk;
  logic rst_n;
  logic req;
  logic ack;
  logic err_overlap, err_spurious, err_dup_ack, err_latency, err_pulse;
  int   n_checks;
  int   n_fail;
  bit   done;

  // flag vector seen by the bench: {overlap, spurious, dup, latency}
  localparam logic [3:0] NONE = 4'b0000;
  localparam logic [3:0] LAT  = 4'b0001;
  localparam logic [3:0] DUP  = 4'b0010;
  localparam logic [3:0] SPUR = 4'b0100;
  localparam logic [3:0] OVL  = 4'b1000;

  hs_monitor #(.MIN_ACK(1), .MAX_ACK(3)) u_hs_monitor (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .ack          (ack),
    .err_overlap  (err_overlap),
    .err_spurious (err_spurious),
    .err_dup_ack  (err_dup_ack),
    .err_latency  (err_latency),
    .err_pulse    (err_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [3:0] flags();
    return {err_overlap, err_spurious, err_dup_ack, err_latency};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req   = 1'b0;
    ack   = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  // request, then acknowledge edge d cycles later; checks at the cycle after the ack edge
  task automatic handshake(input int d, input logic [3:0] exp_flags, input logic exp_pulse, input string tag);
    req = 1'b1;
    if (d == 0) ack = 1'b1;
    step();
    for (int k = 1; k <= d; k++) begin
      if (k == d) ack = 1'b1;
      step();
    end
    check({tag, " flags"}, 32'(flags()), 32'(exp_flags));
    check({tag, " pulse"}, 32'(err_pulse), 32'(exp_pulse));
    ack = 1'b0;
    req = 1'b0;
    step();
    step();
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 reset flags", 32'(flags()), 32'(NONE));
    check("R8 reset pulse", 32'(err_pulse), 0);
  endtask

  task automatic t_window();
    do_reset();
    handshake(1, NONE, 1'b0, "R7 ack at MIN");
    handshake(3, NONE, 1'b0, "R7 ack at MAX");
    handshake(2, NONE, 1'b0, "R7 ack inside");
  endtask

  task automatic t_early();
    do_reset();
    handshake(0, LAT, 1'b1, "R5 same-cycle ack");
    check("R9 pulse one cycle", 32'(err_pulse), 0);
    handshake(2, LAT, 1'b0, "R8 sticky after good txn");
    do_reset();
    check("R8 reset clears sticky", 32'(flags()), 32'(NONE));
  endtask

  task automatic t_timeout();
    do_reset();
    req = 1'b1;
    step(); step(); step();
    check("R6 no flag one cycle before MAX", 32'(flags()), 32'(NONE));
    step();
    check("R6 timeout at MAX", 32'(flags()), 32'(LAT));
    check("R9 timeout pulse", 32'(err_pulse), 1);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R1 held req no new txn", 32'(err_pulse), 0);
    end
    ack = 1'b1;
    step();
    check("R3 ack after timeout", 32'(flags()), 32'(LAT | SPUR));
    ack = 1'b0;
    req = 1'b0;
    step();
  endtask

  task automatic t_spurious();
    do_reset();
    ack = 1'b1;
    step();
    check("R3 ack with no req", 32'(flags()), 32'(SPUR));
    check("R9 spurious pulse", 32'(err_pulse), 1);
    ack = 1'b0;
    step();
  endtask

  task automatic t_dup();
    do_reset();
    req = 1'b1;
    step();
    ack = 1'b1;
    step();
    check("R7 first ack accepted", 32'(flags()), 32'(NONE));
    ack = 1'b0;
    step();
    ack = 1'b1;
    step();
    check("R4 second ack", 32'(flags()), 32'(DUP));
    ack = 1'b0;
    req = 1'b0;
    step(); step();
  endtask

  task automatic t_overlap_with_ack();
    do_reset();
    req = 1'b1;
    step();
    req = 1'b0;
    step();
    req = 1'b1;
    ack = 1'b1;
    step();
    check("R10 overlap plus valid ack flags", 32'(flags()), 32'(OVL));
    check("R2 overlap pulse", 32'(err_pulse), 1);
    step();
    check("R10 held ack no dup", 32'(flags()), 32'(OVL));
    ack = 1'b0;
    req = 1'b0;
    step(); step();
    check("R2 overlap sticky", 32'(flags()), 32'(OVL));
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    req      = 1'b0;
    ack      = 1'b0;
    t_reset();
    t_window();
    t_early();
    t_timeout();
    t_spurious();
    t_dup();
    t_overlap_with_ack();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule